// File: doc/BRIEF.md
# Register Window Availability Tracker

This block keeps the bookkeeping for a windowed register file. It holds four window counters: windows free to save into, windows that can be restored, windows owned by another context, and windows known to be clean. It also holds a 6-bit window-state register that picks trap vectors, and the current window pointer. Each cycle it accepts at most one window command and at most one register write. A command either moves the counters and the pointer, or is refused with a one-cycle trap request that carries a computed trap type.

Five commands exist. Save and restore move the window pointer. Flush only tests whether every window is already spilled. Saved and restored are the acknowledgements a spill or fill handler issues once it has moved a window to or from memory. Trap handling, the register storage and the memory traffic sit outside this block. All results are registered, so an outcome shows on the outputs in the cycle after the command.

Top module: `wavail_top`

## Requirements
- R1: After synchronous reset, cansave is NWIN-2, cleanwin is NWIN-1, and canrestore, otherwin, win_state, cwp, trap_vld and trap_type are all 0.
- R2: A save (cmd_op 0) with cansave 0 raises a spill trap and leaves all counters and cwp unchanged.
- R3: A save with cansave nonzero and cleanwin equal to canrestore (mod 32) raises a clean-window trap of type 0x024 and changes no state.
- R4: Any other save decrements cansave, increments canrestore and moves cwp down by one, wrapping from 0 to NWIN-1.
- R5: A restore (cmd_op 1) with canrestore 0 raises a fill trap. Otherwise it increments cansave, decrements canrestore and moves cwp up by one, wrapping from NWIN-1 to 0.
- R6: The spill type is 0x080 and the fill type is 0x0C0. When otherwin is nonzero, 0x020 is ORed in together with win_state[5:3] placed at trap_type[4:2]. When otherwin is zero, win_state[2:0] is placed at trap_type[4:2].
- R7: A flush (cmd_op 2) raises a spill trap unless cansave equals NWIN-2. It never changes counters or cwp.
- R8: A saved command (cmd_op 3) increments cansave. It then decrements otherwin if otherwin is nonzero, and decrements canrestore otherwise.
- R9: A restored command (cmd_op 4) increments canrestore and increments cleanwin only while cleanwin is below NWIN-1. It then decrements otherwin if otherwin is nonzero, and decrements cansave otherwise.
- R10: When wr_en is high, wr_sel selects the target: 0 cansave, 1 canrestore, 2 otherwin, 3 cleanwin, 4 win_state, 5 cwp, 6 and 7 none. Counters take wr_data[4:0] and win_state takes wr_data[5:0]. A cwp write with a value of NWIN or more is ignored.
- R11: When wr_en and cmd_valid are high in the same cycle, the write is applied and the command is discarded, with no trap.
- R12: trap_vld is high for exactly the cycle after a trapping command. trap_type is 0 whenever trap_vld is low.
- R13: cmd_op values 5 to 7 change nothing and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write target |
| wr_data | input | 6 | Register write value |
| cansave | output | 5 | Windows available for save |
| canrestore | output | 5 | Windows available for restore |
| otherwin | output | 5 | Windows held by another context |
| cleanwin | output | 5 | Clean windows |
| win_state | output | 6 | Trap vector selection fields |
| cwp | output | clog2(NWIN) | Current window pointer |
| trap_vld | output | 1 | One-cycle trap request |
| trap_type | output | 9 | Trap type code |

## Verification
The assertions assume that inputs are sampled only at rising edges. They also assume that cmd_op and wr_sel carry meaning only while their strobes are high. They do not assume the counters stay in a consistent range, because any register write may set them to arbitrary 5-bit values, including cleanwin above NWIN-1. The random stimulus therefore draws write data across the full 6-bit range, including out-of-range cwp values and reserved selects and op codes. It also overlaps writes with commands, so that the properties about priority and saturation are reached from arbitrary states.

// File: rtl/wavail_pkg.sv
package wavail_pkg;
    localparam int CNT_W = 5;
    localparam int WS_W  = 6;
    localparam int TT_W  = 9;
    localparam int WD_W  = 6;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SAVE     = 3'd0,
        OP_RESTORE  = 3'd1,
        OP_FLUSH    = 3'd2,
        OP_SAVED    = 3'd3,
        OP_RESTORED = 3'd4
    } win_op_e;

    typedef enum logic [OP_W-1:0] {
        WS_CANSAVE = 3'd0,
        WS_CANREST = 3'd1,
        WS_OTHER   = 3'd2,
        WS_CLEAN   = 3'd3,
        WS_WSTATE  = 3'd4,
        WS_CWP     = 3'd5
    } wr_sel_e;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_SPILL = 2'd1,
        TK_FILL  = 2'd2,
        TK_CLEAN = 2'd3
    } trap_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0] can_sv;
        logic [CNT_W-1:0] can_rs;
        logic [CNT_W-1:0] other;
        logic [CNT_W-1:0] clean;
        logic [WS_W-1:0]  wst;
    } avail_t;

    function automatic logic [TT_W-1:0] compose_tt(
        input logic [TT_W-1:0] base,
        input logic [TT_W-1:0] oflag,
        input logic [WS_W-1:0] ws,
        input logic            other_nz
    );
        logic [TT_W-1:0] r;
        if (other_nz)
            r = base | oflag | (TT_W'(ws[5:3]) << 2);
        else
            r = base | (TT_W'(ws[2:0]) << 2);
        return r;
    endfunction
endpackage

// File: rtl/wavail_judge.sv
module wavail_judge
    import wavail_pkg::*;
#(
    parameter int              NWIN     = 8,
    parameter logic [TT_W-1:0] TT_SPILL = 9'h080,
    parameter logic [TT_W-1:0] TT_FILL  = 9'h0C0,
    parameter logic [TT_W-1:0] TT_CLEAN = 9'h024,
    parameter logic [TT_W-1:0] TT_OTHER = 9'h020
) (
    input  logic            fire,
    input  logic [OP_W-1:0] op,
    input  avail_t          cur,
    output trap_kind_e      kind,
    output logic [TT_W-1:0] ttype,
    output logic            commit
);
    localparam logic [CNT_W-1:0] FLUSH_OK = CNT_W'(NWIN - 2);

    logic             other_nz;
    logic [CNT_W-1:0] clean_gap;

    assign other_nz  = |cur.other;
    assign clean_gap = cur.clean - cur.can_rs;

    always_comb begin
        kind   = TK_NONE;
        commit = 1'b0;
        if (fire) begin
            case (op)
                OP_SAVE: begin
                    if (cur.can_sv == '0)
                        kind = TK_SPILL;
                    else if (clean_gap == '0)
                        kind = TK_CLEAN;
                    else
                        commit = 1'b1;
                end
                OP_RESTORE: begin
                    if (cur.can_rs == '0)
                        kind = TK_FILL;
                    else
                        commit = 1'b1;
                end
                OP_FLUSH: begin
                    if (cur.can_sv != FLUSH_OK)
                        kind = TK_SPILL;
                end
                OP_SAVED, OP_RESTORED: commit = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (kind)
            TK_SPILL: ttype = compose_tt(TT_SPILL, TT_OTHER, cur.wst, other_nz);
            TK_FILL:  ttype = compose_tt(TT_FILL, TT_OTHER, cur.wst, other_nz);
            TK_CLEAN: ttype = TT_CLEAN;
            default:  ttype = '0;
        endcase
    end
endmodule

// File: rtl/wavail_cnt.sv
module wavail_cnt
    import wavail_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            commit,
    input  logic [OP_W-1:0] op,
    input  logic            wr_en,
    input  logic [OP_W-1:0] wr_sel,
    input  logic [WD_W-1:0] wr_data,
    output avail_t          cur
);
    localparam logic [CNT_W-1:0] SV_RST = CNT_W'(NWIN - 2);
    localparam logic [CNT_W-1:0] CL_TOP = CNT_W'(NWIN - 1);

    avail_t nxt;
    logic   other_nz;

    assign other_nz = |cur.other;

    always_comb begin
        nxt = cur;
        if (wr_en) begin
            case (wr_sel)
                WS_CANSAVE: nxt.can_sv = wr_data[CNT_W-1:0];
                WS_CANREST: nxt.can_rs = wr_data[CNT_W-1:0];
                WS_OTHER:   nxt.other  = wr_data[CNT_W-1:0];
                WS_CLEAN:   nxt.clean  = wr_data[CNT_W-1:0];
                WS_WSTATE:  nxt.wst    = wr_data[WS_W-1:0];
                default: ;
            endcase
        end else if (commit) begin
            case (op)
                OP_SAVE: begin
                    nxt.can_sv = cur.can_sv - 1'b1;
                    nxt.can_rs = cur.can_rs + 1'b1;
                end
                OP_RESTORE: begin
                    nxt.can_sv = cur.can_sv + 1'b1;
                    nxt.can_rs = cur.can_rs - 1'b1;
                end
                OP_SAVED: begin
                    nxt.can_sv = cur.can_sv + 1'b1;
                    if (other_nz) nxt.other  = cur.other - 1'b1;
                    else          nxt.can_rs = cur.can_rs - 1'b1;
                end
                OP_RESTORED: begin
                    nxt.can_rs = cur.can_rs + 1'b1;
                    if (cur.clean < CL_TOP) nxt.clean = cur.clean + 1'b1;
                    if (other_nz) nxt.other  = cur.other - 1'b1;
                    else          nxt.can_sv = cur.can_sv - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.can_sv <= SV_RST;
            cur.can_rs <= '0;
            cur.other  <= '0;
            cur.clean  <= CL_TOP;
            cur.wst    <= '0;
        end else begin
            cur <= nxt;
        end
    end

    // R4: a committed save moves both counters by one in opposite directions
    a_r4_save_counts: assert property (@(posedge clk) disable iff (rst)
        (commit && op == OP_SAVE) |=>
            (cur.can_rs == CNT_W'($past(cur.can_rs) + 1'b1)) &&
            (cur.can_sv == CNT_W'($past(cur.can_sv) - 1'b1)));

    // R9: clean count does not climb past its ceiling
    a_r9_clean_sat: assert property (@(posedge clk) disable iff (rst)
        (commit && op == OP_RESTORED && cur.clean >= CL_TOP) |=> $stable(cur.clean));

    // R8: saved always grows cansave
    a_r8_saved_grows: assert property (@(posedge clk) disable iff (rst)
        (commit && op == OP_SAVED) |=> cur.can_sv == CNT_W'($past(cur.can_sv) + 1'b1));
endmodule

// File: rtl/wavail_cwp.sv
module wavail_cwp
    import wavail_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            commit,
    input  logic [OP_W-1:0] op,
    input  logic            wr_en,
    input  logic [OP_W-1:0] wr_sel,
    input  logic [WD_W-1:0] wr_data,
    output logic [$clog2(NWIN)-1:0] cwp
);
    localparam int              CPW = $clog2(NWIN);
    localparam logic [CPW-1:0]  TOP = CPW'(NWIN - 1);

    logic wr_hit;
    logic wr_ok;

    assign wr_hit = wr_en && (wr_sel == WS_CWP);
    assign wr_ok  = int'(wr_data) < NWIN;

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp <= '0;
        end else if (wr_hit) begin
            if (wr_ok) cwp <= wr_data[CPW-1:0];
        end else if (commit && op == OP_SAVE) begin
            cwp <= (cwp == '0) ? TOP : cwp - 1'b1;
        end else if (commit && op == OP_RESTORE) begin
            cwp <= (cwp == TOP) ? '0 : cwp + 1'b1;
        end
    end

    a_r4_cwp_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (commit && op == OP_SAVE && cwp == '0) |=> cwp == TOP);

    a_r5_cwp_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (commit && op == OP_RESTORE && cwp == TOP) |=> cwp == '0);

    a_r10_cwp_range: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !wr_ok) |=> $stable(cwp));
endmodule

// File: rtl/wavail_top.sv
module wavail_top
    import wavail_pkg::*;
#(
    parameter int              NWIN     = 8,
    parameter logic [TT_W-1:0] TT_SPILL = 9'h080,
    parameter logic [TT_W-1:0] TT_FILL  = 9'h0C0,
    parameter logic [TT_W-1:0] TT_CLEAN = 9'h024,
    parameter logic [TT_W-1:0] TT_OTHER = 9'h020
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    input  logic [OP_W-1:0]         cmd_op,
    input  logic                    wr_en,
    input  logic [OP_W-1:0]         wr_sel,
    input  logic [WD_W-1:0]         wr_data,
    output logic [CNT_W-1:0]        cansave,
    output logic [CNT_W-1:0]        canrestore,
    output logic [CNT_W-1:0]        otherwin,
    output logic [CNT_W-1:0]        cleanwin,
    output logic [WS_W-1:0]         win_state,
    output logic [$clog2(NWIN)-1:0] cwp,
    output logic                    trap_vld,
    output logic [TT_W-1:0]         trap_type
);
    logic            fire;
    logic            commit;
    trap_kind_e      kind;
    logic [TT_W-1:0] ttype;
    avail_t          cur;

    assign fire = cmd_valid && !wr_en;

    wavail_judge #(
        .NWIN(NWIN), .TT_SPILL(TT_SPILL), .TT_FILL(TT_FILL),
        .TT_CLEAN(TT_CLEAN), .TT_OTHER(TT_OTHER)
    ) u_judge (
        .fire(fire), .op(cmd_op), .cur(cur),
        .kind(kind), .ttype(ttype), .commit(commit)
    );

    wavail_cnt #(.NWIN(NWIN)) u_cnt (
        .clk(clk), .rst(rst), .commit(commit), .op(cmd_op),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cur(cur)
    );

    wavail_cwp #(.NWIN(NWIN)) u_cwp (
        .clk(clk), .rst(rst), .commit(commit), .op(cmd_op),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cwp(cwp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_vld  <= 1'b0;
            trap_type <= '0;
        end else begin
            trap_vld  <= (kind != TK_NONE);
            trap_type <= ttype;
        end
    end

    assign cansave    = cur.can_sv;
    assign canrestore = cur.can_rs;
    assign otherwin   = cur.other;
    assign cleanwin   = cur.clean;
    assign win_state  = cur.wst;

    a_r12_idle_type: assert property (@(posedge clk) disable iff (rst)
        !trap_vld |-> trap_type == '0);

    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && wr_en) |=> !trap_vld);

    a_r2_spill_hold: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_op == OP_SAVE && cansave == '0) |=>
            trap_vld && $stable(canrestore) && $stable(cwp) && $stable(cansave));

    a_r7_flush_still: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_op == OP_FLUSH) |=>
            $stable(cansave) && $stable(canrestore) && $stable(otherwin) &&
            $stable(cleanwin) && $stable(cwp));

    a_r5_fill_code: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_op == OP_RESTORE && canrestore == '0) |=>
            trap_vld && trap_type[7:6] == 2'b11);

    a_r13_reserved_op: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_op > 3'd4) |=> !trap_vld && $stable(cwp) && $stable(cansave));
endmodule

// File: tb/sim_wavail_top.sv
`timescale 1ns/1ps
module sim_wavail_top;
    localparam int NW = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic       wr_en;
    logic [2:0] wr_sel;
    logic [5:0] wr_data;
    logic [4:0] cansave, canrestore, otherwin, cleanwin;
    logic [5:0] win_state;
    logic [2:0] cwp;
    logic       trap_vld;
    logic [8:0] trap_type;

    always #2 clk = ~clk;

    wavail_top #(.NWIN(NW)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
        .cleanwin(cleanwin), .win_state(win_state), .cwp(cwp),
        .trap_vld(trap_vld), .trap_type(trap_type)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    int m_sv, m_rs, m_ow, m_cl, m_ws, m_cwp, m_tv, m_tt;

    function automatic int trap_code(int base);
        if (m_ow != 0) return base | 32'h20 | (((m_ws >> 3) & 7) << 2);
        return base | ((m_ws & 7) << 2);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "cansave", int'(cansave), m_sv);
        check(tag, "canrestore", int'(canrestore), m_rs);
        check(tag, "otherwin", int'(otherwin), m_ow);
        check(tag, "cleanwin", int'(cleanwin), m_cl);
        check(tag, "win_state", int'(win_state), m_ws);
        check(tag, "cwp", int'(cwp), m_cwp);
        check(tag, "trap_vld", int'(trap_vld), m_tv);
        check(tag, "trap_type", int'(trap_type), m_tt);
    endtask

    task automatic model(bit v, int op, bit we, int sel, int d);
        m_tv = 0; m_tt = 0;
        if (we) begin
            case (sel)
                0: m_sv = d & 31;
                1: m_rs = d & 31;
                2: m_ow = d & 31;
                3: m_cl = d & 31;
                4: m_ws = d & 63;
                5: if (d < NW) m_cwp = d;
                default: ;
            endcase
        end else if (v) begin
            case (op)
                0: if (m_sv == 0) begin m_tv = 1; m_tt = trap_code(32'h080); end
                   else if (m_cl == m_rs) begin m_tv = 1; m_tt = 32'h024; end
                   else begin
                       m_sv = (m_sv + 31) % 32; m_rs = (m_rs + 1) % 32;
                       m_cwp = (m_cwp + NW - 1) % NW;
                   end
                1: if (m_rs == 0) begin m_tv = 1; m_tt = trap_code(32'h0C0); end
                   else begin
                       m_sv = (m_sv + 1) % 32; m_rs = (m_rs + 31) % 32;
                       m_cwp = (m_cwp + 1) % NW;
                   end
                2: if (m_sv != NW - 2) begin m_tv = 1; m_tt = trap_code(32'h080); end
                3: begin
                       m_sv = (m_sv + 1) % 32;
                       if (m_ow != 0) m_ow = m_ow - 1; else m_rs = (m_rs + 31) % 32;
                   end
                4: begin
                       m_rs = (m_rs + 1) % 32;
                       if (m_cl < NW - 1) m_cl = m_cl + 1;
                       if (m_ow != 0) m_ow = m_ow - 1; else m_sv = (m_sv + 31) % 32;
                   end
                default: ;
            endcase
        end
    endtask

    // Called at a falling edge; leaves at the next falling edge.
    task automatic step(string tag, bit v, int op, bit we, int sel, int d);
        cmd_valid = v; cmd_op = 3'(op);
        wr_en = we; wr_sel = 3'(sel); wr_data = 6'(d);
        model(v, op, we, sel, d);
        @(posedge clk); #1;
        check_all(tag);
        @(negedge clk);
        cmd_valid = 0; wr_en = 0;
    endtask

    task automatic wr(string tag, int sel, int d);
        step(tag, 0, 0, 1, sel, d);
    endtask

    task automatic cmd(string tag, int op);
        step(tag, 1, op, 0, 0, 0);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; cmd_valid = 0; cmd_op = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        m_sv = NW - 2; m_rs = 0; m_ow = 0; m_cl = NW - 1; m_ws = 0; m_cwp = 0;
        m_tv = 0; m_tt = 0;
        #1 check_all("R1");

        cmd("R7 flush all spilled", 2);
        idle("R12 quiet");
        // R6: trap type with otherwin zero and nonzero
        wr("R10", 4, 6'b101_011);
        wr("R10", 0, 0);
        cmd("R2 spill other=0", 0);         // 0x08C
        wr("R10", 2, 2);
        cmd("R6 spill other!=0", 0);        // 0x0B4
        idle("R12 pulse ends");
        cmd("R7 flush trap", 2);
        // R3 clean-window trap
        wr("R10", 2, 0);
        wr("R10", 0, 3);
        wr("R10", 1, 4);
        wr("R10", 3, 4);
        cmd("R3 clean trap", 0);
        // R4 successful save with wrap of cwp 0 -> NW-1
        wr("R10", 3, 7);
        cmd("R4 save wrap", 0);
        // R5 restore wraps back to 0, then fill traps
        cmd("R5 restore wrap", 1);
        wr("R10", 1, 0);
        cmd("R5 fill other=0", 1);
        wr("R10", 2, 1);
        cmd("R6 fill other!=0", 1);
        // R8 saved both branches
        cmd("R8 saved other!=0", 3);
        wr("R10", 1, 2);
        cmd("R8 saved other=0", 3);
        // R9 restored with saturation and both branches
        wr("R10", 3, NW - 1);
        cmd("R9 restored sat", 4);
        wr("R10", 2, 3);
        wr("R10", 3, 2);
        cmd("R9 restored other!=0", 4);
        // R10 cwp write range
        wr("R10 cwp accept", 5, 5);
        wr("R10 cwp reject", 5, 9);
        wr("R10 sel none", 6, 33);
        // R11 write and command together
        wr("R10", 0, 0);
        step("R11 write wins", 1, 0, 1, 3, 12);
        step("R11 write wins restore", 1, 1, 1, 1, 0);
        // R13 reserved ops
        cmd("R13 op5", 5);
        cmd("R13 op7", 7);

        for (int i = 0; i < 3000; i++) begin
            int op, sel, d, r;
            bit v, we;
            string tag;
            r = $urandom_range(0, 99);
            v = r < 80;
            we = $urandom_range(0, 99) < 15;
            op = $urandom_range(0, 7);
            sel = $urandom_range(0, 7);
            d = $urandom_range(0, 63);
            if (we) tag = v ? "R11" : "R10";
            else if (!v) tag = "R12";
            else case (op)
                0: tag = "R4";
                1: tag = "R5";
                2: tag = "R7";
                3: tag = "R8";
                4: tag = "R9";
                default: tag = "R13";
            endcase
            step(tag, v, op, we, sel, d);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule